// File: doc/BRIEF.md
# Four-Direction Edge Gradient Selector

The block takes a raster stream of grayscale pixels and finds the strongest of four directional edge responses at each position: horizontal, +45 degrees, vertical and -45 degrees. Four line buffers and a 5x5 register window supply every pixel site to four 5x5 convolvers that run side by side. A selector reduces their absolute values to a single maximum and a 2-bit direction code. A pixel whose maximum is above a threshold raises one bit of a 4-bit map, one bit per direction. Each map bit position therefore forms a binary significant edge map for its own orientation.

The pixel source marks the first pixel of a frame with a start flag and the last pixel of each line with an end flag. It may pause between pixels by dropping valid. For each accepted pixel at row r and column c, the block emits one result for the site centred at (r-2, c-2). The line width is bounded by a parameter. The threshold and the four kernels are also parameters.

Top module: `edge_dir_select`

## Requirements
- R1: With dr, dc the row and column offsets from the centre (-2..2, rows growing downward) and sgn the sign function, the default kernels are: code 0 is sgn(dr)·(|dc|<=1 ? 2 : 1); code 2 is sgn(dc)·(|dr|<=1 ? 2 : 1); code 1 is sgn(dr+dc)·(|dr-dc|<=1 ? 2 : 1); code 3 is sgn(dr-dc)·(|dr+dc|<=1 ? 2 : 1). Each response is the sum, over all 25 positions, of kernel coefficient times pixel.
- R2: out_mag equals the largest of the four absolute responses at the site.
- R3: out_dir gives the direction of that maximum, coded 0 horizontal, 1 +45, 2 vertical, 3 -45. On a tie the lowest code wins.
- R4: out_map is one-hot with bit out_dir set when out_mag is strictly greater than THRESH. It is all zero otherwise.
- R5: A site whose centre row or centre column is below 2 gives out_mag 0, out_dir 0 and out_map 0.
- R6: A pixel sampled with in_valid at clock edge k produces out_valid high for one cycle after edge k+2. Cycles without in_valid produce no output.
- R7: in_sof puts the current pixel at row 0, column 0. in_eol makes the next pixel column 0 of the following row.
- R8: While rst_n is low, out_valid is 0.
- R9: The result for the pixel at row r, column c belongs to the site centred at row r-2, column c-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | PIX_W | Grayscale pixel |
| out_valid | output | 1 | Result present |
| out_mag | output | PIX_W+6 | Largest absolute gradient |
| out_dir | output | 2 | Winning direction code |
| out_map | output | 4 | Per-direction significance bits |

## Verification
The assertions assume that in_sof and in_eol are only read together with in_valid. They also assume that no line is longer than IMG_W pixels, because longer lines would alias in the line buffers. The stimulus raises the markers only on valid pixels and keeps every line at or below the configured width. Some frames use shorter lines, and one frame inserts idle cycles in the middle of lines. Frames with steps, diagonals, flat areas and pseudo-random content drive each direction code to win in turn and also produce ties at zero.

// File: rtl/edge_pkg.sv
package edge_pkg;
  typedef logic signed [3:0] coef_t;
  typedef coef_t [24:0] kern_t;
  typedef kern_t [3:0] kern_set_t;

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // index = (dr+2)*5 + (dc+2); direction codes 0 horiz, 1 +45, 2 vert, 3 -45
  function automatic kern_set_t default_kernels();
    kern_set_t ks;
    for (int dr = -2; dr <= 2; dr++) begin
      for (int dc = -2; dc <= 2; dc++) begin
        int k;
        k = (dr + 2) * 5 + (dc + 2);
        ks[0][k] = coef_t'(sgn(dr) * ((iabs(dc) <= 1) ? 2 : 1));
        ks[1][k] = coef_t'(sgn(dr + dc) * ((iabs(dr - dc) <= 1) ? 2 : 1));
        ks[2][k] = coef_t'(sgn(dc) * ((iabs(dr) <= 1) ? 2 : 1));
        ks[3][k] = coef_t'(sgn(dr - dc) * ((iabs(dr + dc) <= 1) ? 2 : 1));
      end
    end
    return ks;
  endfunction
endpackage

// File: rtl/edge_window.sv
module edge_window #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic                      in_eol,
  input  logic [PIX_W-1:0]          in_pix,
  output logic [24:0][PIX_W-1:0]    win,
  output logic                      win_valid,
  output logic                      win_border
);
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic [2:0]    row_q, row_n, cur_row;
  logic [CW-1:0] col_q, col_n, cur_col;
  logic          border_n;

  logic [PIX_W-1:0] lb [4][IMG_W];
  logic [4:0][PIX_W-1:0] colvec;
  logic [PIX_W-1:0] wreg [5][5];

  // position tracking: next-state
  always_comb begin
    cur_row  = in_sof ? 3'd0 : row_q;
    cur_col  = in_sof ? '0 : col_q;
    row_n    = row_q;
    col_n    = col_q;
    if (in_valid) begin
      if (in_eol) begin
        row_n = (cur_row == 3'd4) ? 3'd4 : cur_row + 3'd1;
        col_n = '0;
      end else begin
        row_n = cur_row;
        col_n = cur_col + CW'(1);
      end
    end
    border_n = (cur_row < 3'd4) || (cur_col < CW'(4));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q      <= '0;
      col_q      <= '0;
      win_valid  <= 1'b0;
      win_border <= 1'b1;
    end else begin
      row_q     <= row_n;
      col_q     <= col_n;
      win_valid <= in_valid;
      if (in_valid) win_border <= border_n;
    end
  end

  assign colvec[4] = in_pix;

  for (genvar g = 0; g < 4; g++) begin : g_line
    assign colvec[3-g] = lb[g][cur_col];
    always_ff @(posedge clk) begin
      if (in_valid) lb[g][cur_col] <= colvec[4-g];
    end
  end

  for (genvar i = 0; i < 5; i++) begin : g_wrow
    for (genvar j = 0; j < 5; j++) begin : g_wcol
      if (j == 4) begin : g_new
        always_ff @(posedge clk) begin
          if (in_valid) wreg[i][j] <= colvec[i];
        end
      end else begin : g_shift
        always_ff @(posedge clk) begin
          if (in_valid) wreg[i][j] <= wreg[i][j+1];
        end
      end
      assign win[i*5+j] = wreg[i][j];
    end
  end
endmodule

// File: rtl/edge_conv.sv
module edge_conv #(
  parameter int            PIX_W = 8,
  parameter edge_pkg::kern_t KERN = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [24:0][PIX_W-1:0]     win,
  output logic [PIX_W+5:0]           mag_q
);
  localparam int SUM_W = PIX_W + 7;
  localparam int MAG_W = PIX_W + 6;

  logic signed [SUM_W-1:0] acc, cw, pw;
  logic [MAG_W-1:0]        mag_n;

  always_comb begin
    acc = '0;
    for (int k = 0; k < 25; k++) begin
      cw  = SUM_W'(KERN[k]);
      pw  = SUM_W'(win[k]);
      acc = acc + cw * pw;
    end
    mag_n = acc[SUM_W-1] ? MAG_W'(-acc) : MAG_W'(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mag_q <= '0;
    else if (en) mag_q <= mag_n;
  end
endmodule

// File: rtl/edge_select.sv
module edge_select #(
  parameter int          MAG_W  = 14,
  parameter int unsigned THRESH = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  border,
  input  logic [3:0][MAG_W-1:0] mags,
  output logic [MAG_W-1:0]      mag_q,
  output logic [1:0]            dir_q,
  output logic [3:0]            map_q
);
  logic [MAG_W-1:0] best;
  logic [1:0]       bdir;
  logic [3:0]       map_n;

  always_comb begin
    best = mags[0];
    bdir = 2'd0;
    for (int d = 1; d < 4; d++) begin
      if (mags[d] > best) begin
        best = mags[d];
        bdir = 2'(d);
      end
    end
    if (border) begin
      best = '0;
      bdir = 2'd0;
    end
    map_n = (best > MAG_W'(THRESH)) ? (4'b0001 << bdir) : 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      dir_q <= '0;
      map_q <= '0;
    end else if (en) begin
      mag_q <= best;
      dir_q <= bdir;
      map_q <= map_n;
    end
  end
endmodule

// File: rtl/edge_dir_select.sv
module edge_dir_select #(
  parameter int                  PIX_W   = 8,
  parameter int                  IMG_W   = 64,
  parameter int unsigned         THRESH  = 64,
  parameter edge_pkg::kern_set_t KERNELS = edge_pkg::default_kernels()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [PIX_W+5:0] out_mag,
  output logic [1:0]       out_dir,
  output logic [3:0]       out_map
);
  localparam int MAG_W = PIX_W + 6;

  logic [24:0][PIX_W-1:0] win;
  logic                   win_valid, win_border;
  logic [3:0][MAG_W-1:0]  mags;
  logic                   v2_q, b2_q;

  edge_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_pix(in_pix), .win(win), .win_valid(win_valid),
    .win_border(win_border)
  );

  for (genvar d = 0; d < 4; d++) begin : g_dir
    edge_conv #(.PIX_W(PIX_W), .KERN(KERNELS[d])) u_conv (
      .clk(clk), .rst_n(rst_n), .en(win_valid), .win(win), .mag_q(mags[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q      <= 1'b0;
      b2_q      <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      v2_q      <= win_valid;
      out_valid <= v2_q;
      if (win_valid) b2_q <= win_border;
    end
  end

  edge_select #(.MAG_W(MAG_W), .THRESH(THRESH)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(v2_q), .border(b2_q), .mags(mags),
    .mag_q(out_mag), .dir_q(out_dir), .map_q(out_map)
  );
endmodule

// File: rtl/edge_dir_select_chk.sv
module edge_dir_select_chk #(
  parameter int          PIX_W  = 8,
  parameter int unsigned THRESH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W+5:0] out_mag,
  input logic [1:0]       out_dir,
  input logic [3:0]       out_map
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_MAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_map)); // R4
  AST_MAP_AT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_map != 4'b0) |-> out_map[out_dir]); // R3
  AST_MAP_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_map != 4'b0) |-> (out_mag > (PIX_W+6)'(THRESH))); // R4
  AST_THR_SETS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mag > (PIX_W+6)'(THRESH)) |-> (out_map != 4'b0)); // R4
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R6

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (out_valid == 1'b0); // R8
  end
endmodule

bind edge_dir_select edge_dir_select_chk #(.PIX_W(PIX_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_mag(out_mag), .out_dir(out_dir), .out_map(out_map)
);

// File: tb/tb_edge_dir_select.sv
module tb_edge_dir_select;
  localparam int PIX_W = 8;
  localparam int IMG_W = 12;
  localparam int THR   = 40;
  localparam int HMAX  = 4096;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             out_valid;
  logic [PIX_W+5:0] out_mag;
  logic [1:0]       out_dir;
  logic [3:0]       out_map;

  always #5 clk = ~clk;

  edge_dir_select #(.PIX_W(PIX_W), .IMG_W(IMG_W), .THRESH(THR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_pix(in_pix), .out_valid(out_valid),
    .out_mag(out_mag), .out_dir(out_dir), .out_map(out_map)
  );

  int checks = 0, fails = 0, cyc = 0;
  int img [0:15][0:IMG_W-1];
  int prow = 0, pcol = 0;
  bit hv [HMAX];
  int hmag [HMAX], hdir [HMAX], hmap [HMAX];
  bit hbord [HMAX];
  int lfsr = 16'hACE1;
  bit done = 0;

  function automatic int sg(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction
  function automatic int ab(input int v);
    return (v < 0) ? -v : v;
  endfunction
  // R1 kernel coefficients, spelled out from the requirement
  function automatic int coef(input int d, input int dr, input int dc);
    case (d)
      0: return sg(dr) * ((ab(dc) <= 1) ? 2 : 1);
      1: return sg(dr + dc) * ((ab(dr - dc) <= 1) ? 2 : 1);
      2: return sg(dc) * ((ab(dr) <= 1) ? 2 : 1);
      default: return sg(dr - dc) * ((ab(dr + dc) <= 1) ? 2 : 1);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock: compare outputs, then drive inputs and record the expectation
  task automatic tick(input bit v, input bit sof, input bit eol, input int pix);
    @(negedge clk);
    if (cyc >= 3) begin
      int k;
      k = cyc - 3;
      check(out_valid == hv[k], "R6 out_valid", int'(out_valid), int'(hv[k]));
      if (hv[k]) begin
        check(int'(out_mag) == hmag[k], hbord[k] ? "R5/R7 border mag" : "R1/R2/R9 mag",
              int'(out_mag), hmag[k]);
        check(int'(out_dir) == hdir[k], hbord[k] ? "R5 border dir" : "R3 dir",
              int'(out_dir), hdir[k]);
        check(int'(out_map) == hmap[k], hbord[k] ? "R5 border map" : "R4 map",
              int'(out_map), hmap[k]);
      end
    end
    in_valid = v; in_sof = sof; in_eol = eol; in_pix = PIX_W'(pix);
    hv[cyc] = v;
    if (v) begin
      int r, c, best, bd;
      if (sof) begin prow = 0; pcol = 0; end   // R7
      r = prow; c = pcol;
      img[r][c] = pix;
      best = 0; bd = 0;
      hbord[cyc] = (r < 4) || (c < 4);          // R5, R9: centre (r-2,c-2)
      if (!hbord[cyc]) begin
        for (int d = 0; d < 4; d++) begin
          int s;
          s = 0;
          for (int dr = -2; dr <= 2; dr++)
            for (int dc = -2; dc <= 2; dc++)
              s += coef(d, dr, dc) * img[r-2+dr][c-2+dc];
          if (ab(s) > best) begin best = ab(s); bd = d; end
        end
      end
      hmag[cyc] = best; hdir[cyc] = bd;
      hmap[cyc] = (best > THR) ? (1 << bd) : 0;
      if (eol) begin
        prow = (prow < 15) ? prow + 1 : 15;
        pcol = 0;
      end else pcol++;
    end
    cyc++;
  endtask

  function automatic int pick(input int f, input int r, input int c);
    case (f)
      0: return 100;
      1: return (c < 6) ? 20 : 200;
      2: return (r < 4) ? 30 : 220;
      3: return ((r + c) < 9) ? 10 : 240;
      5: return ((c - r) > 2) ? 250 : 5;
      default: return lfsr & 255;
    endcase
  endfunction

  task automatic frame(input int f, input int rows, input int cols, input bit gaps);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
        if (gaps && (lfsr & 3) == 0) tick(1'b0, 1'b0, 1'b0, 0);
        tick(1'b1, (r == 0 && c == 0), (c == cols - 1), pick(f, r, c));
      end
    end
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) tick(1'b0, 1'b0, 1'b0, 0);
    frame(0, 7, IMG_W, 1'b0);      // flat: all ties at zero, R3
    frame(1, 7, IMG_W, 1'b0);      // vertical step
    frame(2, 8, IMG_W, 1'b0);      // horizontal step
    frame(3, 8, IMG_W, 1'b0);      // diagonal
    frame(4, 6, 10, 1'b1);         // random, short lines, idle gaps, R7
    frame(5, 8, IMG_W, 1'b0);      // other diagonal
    frame(4, 7, IMG_W, 1'b1);
    repeat (5) tick(1'b0, 1'b0, 1'b0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule